// File: doc/BRIEF.md
# PS/2 Receive Controller with Auto-Inhibit

This block takes serial frames from a PS/2-style keyboard. The device drives an open-drain clock line and a data line. Both inputs are brought through a two-flop synchronizer into the system clock domain. On each falling edge of the synchronized device clock, the block samples one bit. A frame has eleven bits in a fixed order: a low start bit, eight data bits with the least-significant bit first, an odd-parity bit and a stop bit.

When the last bit arrives, the block does three things in the same system clock cycle. It latches the byte into a read-only data register. It sets a buffer-full flag. It pulls the device clock line low, which inhibits further traffic from the keyboard. If software has enabled the interrupt, the interrupt output rises in that same cycle.

Software works through a small register port. It turns on the line interface first. Then it arms the receiver, which is only accepted while both lines read idle-high. Software then reads the byte and clears the full flag. Clearing the flag releases the clock line and lets the next frame in.

Top module: `ps2_rx_inhibit`

## Requirements
- R1: After reset, the control register (address 0) reads 0. Status bits 2:0 (address 1) read 0. The data register (address 2) reads 0. `kclk_low` and `irq` are both 0.
- R2: The control register has three bits. Bit 0 turns on the line interface, bit 1 arms the receiver and bit 2 enables the interrupt. A write may move bit 1 from 0 to 1 only when all of these hold at the write: bit 0 is already 1, bit 0 is 1 in the written value, and the synchronized clock and data lines are both 1. Any write with bit 0 equal to 0 clears bit 1. Bit 2 always takes the written value.
- R3: A falling clock edge that finds the data line high while no frame is in progress starts nothing.
- R4: The eight data bits are assembled least-significant first. After the frame, they appear at address 2.
- R5: Status bit 1 is the parity error flag. It is set when the eight data bits plus the parity bit hold an even number of ones, and it is 0 when that count is odd.
- R6: Status bit 2 holds the level sampled for the stop bit.
- R7: On the falling edge that carries the stop bit, status bit 0 (full) and `kclk_low` both become 1 in the same cycle.
- R8: `irq` is 1 exactly when the full flag is set and control bit 2 is 1.
- R9: While full is set, clock edges are ignored, and the data register and status flags keep their values.
- R10: Writing address 1 with bit 0 equal to 0 clears full and releases `kclk_low` on the next cycle. After that, a new frame is received normally.
- R11: Clearing control bit 1 in the middle of a frame discards the partial frame. The next frame received after re-arming is assembled from its own start bit.
- R12: Status bits 3 and 4 report the synchronized clock and data line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kclk_in | input | 1 | Device clock line as seen on the pin |
| kdat_in | input | 1 | Device data line as seen on the pin |
| kclk_low | output | 1 | 1 pulls the device clock line low (inhibit) |
| irq | output | 1 | Receive interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 3 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
The assertions assume that the device clock holds each level for several system clock cycles, so that every falling edge is seen exactly once after synchronization. They also assume that register writes are single-cycle strobes. The stimulus keeps each clock phase four system cycles long and drives the pins through a wired-AND with `kclk_low`, so that line behaves like the real open-drain line. The bench changes data only while the clock is high, and it drives register writes for one cycle.

// File: rtl/ps2_rx_inhibit.sv
module ps2_rx_inhibit #(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kclk_in,
  input  logic       kdat_in,
  output logic       kclk_low,
  output logic       irq,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [2:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int CNT_W  = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(DATA_W + 2);

  logic [1:0] clk_sy, dat_sy;
  logic clk_q, clk_s1, dat_s1, fall;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] shreg, data_q;
  logic par_q, full, perr, stopv;
  logic io_en, rx_en, irq_en;
  logic wr_ctrl, wr_stat, take;

  assign clk_s1  = clk_sy[1];
  assign dat_s1  = dat_sy[1];
  assign fall    = clk_q & ~clk_s1;
  assign wr_ctrl = wr_en && wr_addr == 2'd0;
  assign wr_stat = wr_en && wr_addr == 2'd1;
  assign take    = rx_en && !full && fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy <= 2'b11;
      dat_sy <= 2'b11;
      clk_q  <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[0], kclk_in};
      dat_sy <= {dat_sy[0], kdat_in};
      clk_q  <= clk_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shreg  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
      full   <= 1'b0;
      perr   <= 1'b0;
      stopv  <= 1'b0;
      io_en  <= 1'b0;
      rx_en  <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (!rx_en) begin
        cnt <= '0;
      end else if (take) begin
        if (cnt == '0) begin
          if (!dat_s1) begin
            cnt   <= CNT_W'(1);
            shreg <= '0;
          end
        end else if (cnt < PAR_IDX) begin
          shreg <= {dat_s1, shreg[DATA_W-1:1]};
          cnt   <= cnt + CNT_W'(1);
        end else if (cnt == PAR_IDX) begin
          par_q <= dat_s1;
          cnt   <= STOP_IDX;
        end else begin
          full   <= 1'b1;
          data_q <= shreg;
          perr   <= ~(^{par_q, shreg});
          stopv  <= dat_s1;
          cnt    <= '0;
        end
      end
      if (wr_ctrl) begin
        io_en  <= wr_data[0];
        irq_en <= wr_data[2];
        rx_en  <= wr_data[0] & wr_data[1] & (rx_en | (io_en & clk_s1 & dat_s1));
      end
      if (wr_stat && !wr_data[0]) full <= 1'b0;
    end
  end

  assign kclk_low = full;
  assign irq      = full & irq_en;

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      2'd0: rd_data = {5'b0, irq_en, rx_en, io_en};
      2'd1: rd_data = {3'b0, dat_s1, clk_s1, stopv, perr, full};
      2'd2: rd_data = 8'(data_q);
      default: rd_data = 8'h00;
    endcase
  end
endmodule

module ps2_rx_inhibit_chk #(
  parameter int CNT_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [2:0]        wr_data,
  input logic              kclk_low,
  input logic              irq,
  input logic              io_en,
  input logic              rx_en,
  input logic              clk_s1,
  input logic              dat_s1,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] data_q
);
  assert_arm_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> $past(io_en && clk_s1 && dat_s1));
  assert_inhibit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kclk_low) |-> $past(cnt) == CNT_W'(DATA_W + 2));
  assert_irq_only_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> kclk_low);
  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kclk_low && $past(kclk_low)) |-> $stable(data_q));
  assert_release_by_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kclk_low) |-> $past(wr_en && wr_addr == 2'd1 && !wr_data[0]));
  assert_abort_resets_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> cnt == '0);
endmodule

bind ps2_rx_inhibit ps2_rx_inhibit_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_ps2_rx_inhibit.sv
module test_ps2_rx_inhibit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic kclk_low, irq;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [2:0] wr_data = 3'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic kclk_wire;

  int compared = 0, mismatched = 0;
  bit started = 0, done = 0;

  always #5 clk = ~clk;
  assign kclk_wire = dev_clk & ~kclk_low;

  ps2_rx_inhibit i_ps2_rx_inhibit (
    .clk(clk), .rst_n(rst_n), .kclk_in(kclk_wire), .kdat_in(dev_dat),
    .kclk_low(kclk_low), .irq(irq), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  bit ch[$], dh[$];
  int m_bit;
  logic [7:0] m_sh, m_data;
  logic m_par, m_full, m_perr, m_stop, m_io, m_rx, m_irqen;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rd(logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_irqen, m_rx, m_io};
      2'd1: return {3'b0, logic'(dh[1]), logic'(ch[1]), m_stop, m_perr, m_full};
      2'd2: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ch = '{1, 1, 1}; dh = '{1, 1, 1};
      m_bit = 0; m_sh = 0; m_data = 0; m_par = 0; m_full = 0; m_perr = 0;
      m_stop = 0; m_io = 0; m_rx = 0; m_irqen = 0;
    end else begin
      bit fl, d, cidle, didle;
      logic rx_old;
      fl = ch[2] && !ch[1];
      d = dh[1]; cidle = ch[1]; didle = dh[1];
      rx_old = m_rx;
      if (!rx_old) m_bit = 0;
      else if (!m_full && fl) begin
        if (m_bit == 0) begin
          if (!d) begin m_bit = 1; m_sh = 0; end
        end else if (m_bit <= 8) begin
          m_sh[m_bit-1] = d; m_bit++;
        end else if (m_bit == 9) begin
          m_par = d; m_bit = 10;
        end else begin
          m_full = 1; m_data = m_sh; m_stop = d; m_bit = 0;
          m_perr = (($countones(m_sh) + int'(m_par)) % 2) == 0;
        end
      end
      if (wr_en && wr_addr == 2'd0) begin
        m_rx = wr_data[0] && wr_data[1] && (rx_old || (m_io && cidle && didle));
        m_io = wr_data[0]; m_irqen = wr_data[2];
      end
      if (wr_en && wr_addr == 2'd1 && !wr_data[0]) m_full = 0;
    end
    ch.push_front(dev_clk & ~kclk_low); void'(ch.pop_back());
    dh.push_front(dev_dat); void'(dh.pop_back());
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R7 line", {7'b0, kclk_low}, {7'b0, m_full});
      chk("R8 irq", {7'b0, irq}, {7'b0, m_full & m_irqen});
      chk(rd_addr == 0 ? "R2 ctrl" : rd_addr == 1 ? "R5/R12 stat" : "R4 data",
          rd_data, m_rd(rd_addr));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [1:0] a, logic [2:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0; tick();
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data; tick();
  endtask

  task automatic send_bit(bit b);
    dev_dat = b; tick(4); dev_clk = 0; tick(4); dev_clk = 1; tick(2);
  endtask

  task automatic send_frame(logic [7:0] b, bit good_par, bit stop);
    send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(good_par ? ~^b : ^b);
    send_bit(stop);
    dev_dat = 1; tick(6);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(3); rst_n = 1; tick(2);
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 stat", v & 8'h07, 8'h00);
    rd(2, v); chk("R1 data", v, 8'h00);
    chk("R1 outputs", {6'b0, kclk_low, irq}, 8'h00);

    wr(0, 3'b110); rd(0, v); chk("R2 arm without line enable", v, 8'h04);
    wr(0, 3'b101);
    dev_dat = 0; tick(4);
    wr(0, 3'b111); rd(0, v); chk("R2 arm with busy line", v, 8'h05);
    rd(1, v); chk("R12 data level low", v & 8'h18, 8'h08);
    dev_dat = 1; tick(4);
    rd(1, v); chk("R12 lines idle", v & 8'h18, 8'h18);
    wr(0, 3'b111); rd(0, v); chk("R2 arm accepted", v, 8'h07);

    send_bit(1); tick(4);
    send_frame(8'h3C, 1, 1);
    rd(2, v); chk("R3/R4 data after spurious edge", v, 8'h3C);
    rd(1, v); chk("R5 R6 R7 status good frame", v & 8'h07, 8'h05);
    chk("R7 inhibit", {7'b0, kclk_low}, 8'h01);
    chk("R8 irq raised", {7'b0, irq}, 8'h01);

    send_frame(8'h55, 1, 1);
    rd(2, v); chk("R9 data held while full", v, 8'h3C);
    rd(1, v); chk("R9 flags held", v & 8'h07, 8'h05);

    wr(1, 3'b000);
    chk("R10 line released", {7'b0, kclk_low}, 8'h00);
    send_frame(8'h81, 0, 0);
    rd(2, v); chk("R4 R10 second frame", v, 8'h81);
    rd(1, v); chk("R5 R6 bad parity zero stop", v & 8'h07, 8'h03);
    wr(0, 3'b011);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    wr(1, 3'b000);

    send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    wr(0, 3'b001); dev_dat = 1; tick(4);
    wr(0, 3'b011);
    send_frame(8'h42, 1, 1);
    rd(2, v); chk("R11 frame after abort", v, 8'h42);
    rd(1, v); chk("R11 status after abort", v & 8'h07, 8'h05);
    wr(1, 3'b000);
    send_frame(8'hFF, 1, 1);
    rd(2, v); chk("R4 all ones", v, 8'hFF);
    tick(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule